// File: doc/BRIEF.md
# Conditional Jump Decision Unit

This unit settles whether a compare-and-jump instruction is taken and which instruction pointer comes next. It receives a 4-bit condition code and a 32-bit first operand. The second operand is either a 32-bit register value or a 16-bit immediate, and a form-select input picks between them. The immediate is sign-extended to 32 bits before the compare. The same condition codes serve both forms.

The unit also receives the current instruction pointer and a precomputed jump target. When the input strobe is high, it registers three results on the next rising clock edge: a taken flag, a flag for an invalid condition, and the next pointer. The next pointer is the target when the jump is taken and the current pointer plus one step otherwise. Less-than style jumps are produced by swapping operands ahead of this unit, so the hardware decodes only seven codes. Every other code is reported as an invalid condition.

Top module: `jump_eval_top`

## Requirements
- R1: While `rst` is high at a rising edge, the following edge leaves `out_valid`, `out_taken` and `out_bad_cond` at 0 and `out_next_ptr` at 0.
- R2: Condition code 4'h0 is always taken, whatever the operands are.
- R3: Code 4'h1 is taken when the operands differ. Code 4'h2 is taken when the operands are equal.
- R4: Code 4'h3 is taken when the first operand is greater than the second as unsigned numbers. Code 4'h4 is taken when it is greater than or equal, unsigned.
- R5: Code 4'hC is taken when the first operand is greater than the second as two's complement numbers. Code 4'hD is taken when it is greater than or equal, two's complement.
- R6: When `form_imm` is 1, the second operand is `imm_field` sign-extended from bit 15 and `opnd_b_reg` has no effect. When `form_imm` is 0, the second operand is `opnd_b_reg`.
- R7: Codes 4'h5 to 4'hB, 4'hE and 4'hF set `out_bad_cond` to 1 and leave `out_taken` at 0. Valid codes set `out_bad_cond` to 0.
- R8: `out_next_ptr` equals `target_ptr` when the jump is taken. Otherwise it equals `cur_ptr + 1`, wrapping modulo 2^32.
- R9: The results of a strobed input appear one edge after `in_valid` is high, and `out_valid` is 1 for that cycle. Edges with `in_valid` low drive `out_valid` to 0 and hold `out_taken`, `out_bad_cond` and `out_next_ptr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input strobe; the operands are evaluated at this edge |
| form_imm | input | 1 | 1 selects the immediate form, 0 selects the register form |
| cond_code | input | 4 | Jump condition code |
| opnd_a | input | 32 | First operand |
| opnd_b_reg | input | 32 | Second operand for the register form |
| imm_field | input | 16 | Immediate for the immediate form |
| cur_ptr | input | 32 | Current instruction pointer |
| target_ptr | input | 32 | Jump target address |
| out_valid | output | 1 | Results are fresh this cycle |
| out_taken | output | 1 | The jump is taken |
| out_bad_cond | output | 1 | The condition code is reserved |
| out_next_ptr | output | 32 | Next instruction pointer |

## Verification
The bench applies every one of the 16 condition codes in both forms to a grid of operands. The grid includes zero, one, a small value, the largest positive number, the most negative number and all ones. Equal pairs separate the strict codes from the or-equal codes. Pairs whose sign bits differ give opposite answers in unsigned and signed compares, so a swapped or mis-typed compare shows up. Immediates with bit 15 set, paired with a register operand that differs from them, show whether sign extension is done and whether the register operand leaks into the immediate form. Idle cycles with changed inputs, and a current pointer of all ones, test the hold behaviour and the wrap of the increment.

// File: rtl/jump_eval_pkg.sv
package jump_eval_pkg;

  localparam int COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    CC_ALWAYS = 4'h0,
    CC_NE     = 4'h1,
    CC_EQ     = 4'h2,
    CC_UGT    = 4'h3,
    CC_UGE    = 4'h4,
    CC_SGT    = 4'hC,
    CC_SGE    = 4'hD
  } cond_e;

  typedef struct packed {
    logic eq;
    logic ugt;
    logic sgt;
  } cmp_flags_t;

endpackage

// File: rtl/jump_operand_sel.sv
module jump_operand_sel #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic              form_imm,
  input  logic [DATA_W-1:0] reg_val,
  input  logic [IMM_W-1:0]  imm_val,
  output logic [DATA_W-1:0] opnd_b
);
  localparam int EXT_W = DATA_W - IMM_W;

  logic [DATA_W-1:0] imm_ext;

  generate
    if (EXT_W > 0) begin : g_ext
      assign imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
    end else begin : g_noext
      assign imm_ext = imm_val[DATA_W-1:0];
    end
  endgenerate

  assign opnd_b = form_imm ? imm_ext : reg_val;

endmodule

// File: rtl/jump_compare.sv
module jump_compare
  import jump_eval_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output cmp_flags_t        flags
);
  localparam int MSB = DATA_W - 1;

  logic equal, u_less, u_great, sign_split;

  always_comb begin
    equal      = (a == b);
    u_less     = (a < b);
    u_great    = !u_less && !equal;
    sign_split = a[MSB] ^ b[MSB];
    flags.eq   = equal;
    flags.ugt  = u_great;
    // differing signs: the non-negative one is larger
    flags.sgt  = sign_split ? !a[MSB] : u_great;
  end

endmodule

// File: rtl/jump_cond_decode.sv
module jump_cond_decode
  import jump_eval_pkg::*;
(
  input  logic [COND_W-1:0] code,
  input  cmp_flags_t        flags,
  output logic              take,
  output logic              bad
);
  always_comb begin
    take = 1'b0;
    bad  = 1'b0;
    case (code)
      CC_ALWAYS: take = 1'b1;
      CC_NE:     take = !flags.eq;
      CC_EQ:     take = flags.eq;
      CC_UGT:    take = flags.ugt;
      CC_UGE:    take = flags.ugt | flags.eq;
      CC_SGT:    take = flags.sgt;
      CC_SGE:    take = flags.sgt | flags.eq;
      default:   bad  = 1'b1;
    endcase
  end
endmodule

// File: rtl/jump_eval_top.sv
module jump_eval_top
  import jump_eval_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IMM_W    = 16,
  parameter int PTR_W    = 32,
  parameter int PTR_STEP = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              form_imm,
  input  logic [3:0]        cond_code,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b_reg,
  input  logic [IMM_W-1:0]  imm_field,
  input  logic [PTR_W-1:0]  cur_ptr,
  input  logic [PTR_W-1:0]  target_ptr,
  output logic              out_valid,
  output logic              out_taken,
  output logic              out_bad_cond,
  output logic [PTR_W-1:0]  out_next_ptr
);
  localparam logic [PTR_W-1:0] STEP = PTR_W'(PTR_STEP);

  logic [DATA_W-1:0] opnd_b;
  cmp_flags_t        flags;
  logic              take_c, bad_c;
  logic [PTR_W-1:0]  seq_ptr, next_c;

  jump_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sel (
    .form_imm (form_imm),
    .reg_val  (opnd_b_reg),
    .imm_val  (imm_field),
    .opnd_b   (opnd_b)
  );

  jump_compare #(.DATA_W(DATA_W)) u_cmp (
    .a     (opnd_a),
    .b     (opnd_b),
    .flags (flags)
  );

  jump_cond_decode u_dec (
    .code  (cond_code),
    .flags (flags),
    .take  (take_c),
    .bad   (bad_c)
  );

  assign seq_ptr = cur_ptr + STEP;
  assign next_c  = take_c ? target_ptr : seq_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_taken    <= 1'b0;
      out_bad_cond <= 1'b0;
      out_next_ptr <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_taken    <= take_c;
        out_bad_cond <= bad_c;
        out_next_ptr <= next_c;
      end
    end
  end

endmodule

// File: rtl/jump_eval_checker.sv
module jump_eval_checker #(
  parameter int PTR_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [3:0]       cond_code,
  input logic [PTR_W-1:0] cur_ptr,
  input logic [PTR_W-1:0] target_ptr,
  input logic             out_valid,
  input logic             out_taken,
  input logic             out_bad_cond,
  input logic [PTR_W-1:0] out_next_ptr
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (!out_valid && !out_taken && !out_bad_cond && out_next_ptr == '0));

  a_r2_always_taken: assert property (@(posedge clk) disable iff (rst)
    (in_valid && cond_code == 4'h0) |=> out_taken);

  a_r7_bad_not_taken: assert property (@(posedge clk) disable iff (rst)
    out_bad_cond |-> !out_taken);

  a_r8_next_pointer: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_next_ptr == (out_taken ? $past(target_ptr)
                                             : $past(cur_ptr) + 1'b1)));

  a_r9_strobe_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_taken) && $stable(out_bad_cond)
                   && $stable(out_next_ptr)));
endmodule

bind jump_eval_top jump_eval_checker #(.PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .cond_code    (cond_code),
  .cur_ptr      (cur_ptr),
  .target_ptr   (target_ptr),
  .out_valid    (out_valid),
  .out_taken    (out_taken),
  .out_bad_cond (out_bad_cond),
  .out_next_ptr (out_next_ptr)
);

// File: tb/sim_jump_eval_top.sv
`timescale 1ns/1ps
module sim_jump_eval_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        form_imm = 1'b0;
  logic [3:0]  cond_code = 4'h0;
  logic [31:0] opnd_a = '0, opnd_b_reg = '0, cur_ptr = '0, target_ptr = '0;
  logic [15:0] imm_field = '0;
  logic        out_valid, out_taken, out_bad_cond;
  logic [31:0] out_next_ptr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  jump_eval_top u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .form_imm(form_imm),
    .cond_code(cond_code), .opnd_a(opnd_a), .opnd_b_reg(opnd_b_reg),
    .imm_field(imm_field), .cur_ptr(cur_ptr), .target_ptr(target_ptr),
    .out_valid(out_valid), .out_taken(out_taken), .out_bad_cond(out_bad_cond),
    .out_next_ptr(out_next_ptr)
  );

  function automatic logic [31:0] pick(input int i);
    case (i)
      0: pick = 32'h0000_0000;
      1: pick = 32'h0000_0001;
      2: pick = 32'h0000_0005;
      3: pick = 32'h7FFF_FFFF;
      4: pick = 32'h8000_0000;
      default: pick = 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic logic [15:0] pick_imm(input int i);
    case (i)
      0: pick_imm = 16'h0000;
      1: pick_imm = 16'h0001;
      2: pick_imm = 16'h0005;
      3: pick_imm = 16'h7FFF;
      4: pick_imm = 16'h8000;
      default: pick_imm = 16'hFFFF;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one strobed vector; returns after the result edge, away from the edge
  task automatic apply(input logic [3:0] c, input logic imm_sel,
                       input logic [31:0] a, input logic [31:0] br,
                       input logic [15:0] im, input logic [31:0] cp,
                       input logic [31:0] tp);
    logic [31:0] b;
    logic        exp_t, exp_bad;
    string       tag;
    @(negedge clk);
    in_valid = 1'b1; cond_code = c; form_imm = imm_sel; opnd_a = a;
    opnd_b_reg = br; imm_field = im; cur_ptr = cp; target_ptr = tp;
    b = imm_sel ? {{16{im[15]}}, im} : br;
    exp_bad = 1'b0;
    case (c)
      4'h0: begin exp_t = 1'b1; tag = "R2"; end
      4'h1: begin exp_t = (a != b); tag = "R3"; end
      4'h2: begin exp_t = (a == b); tag = "R3"; end
      4'h3: begin exp_t = (a > b); tag = "R4"; end
      4'h4: begin exp_t = (a >= b); tag = "R4"; end
      4'hC: begin exp_t = ($signed(a) > $signed(b)); tag = "R5"; end
      4'hD: begin exp_t = ($signed(a) >= $signed(b)); tag = "R5"; end
      default: begin exp_t = 1'b0; exp_bad = 1'b1; tag = "R7"; end
    endcase
    if (imm_sel) tag = {tag, "/R6"};
    @(posedge clk);
    #1;
    chk({tag, " taken"}, {31'b0, out_taken}, {31'b0, exp_t});
    chk("R7 bad_cond", {31'b0, out_bad_cond}, {31'b0, exp_bad});
    chk("R8 next_ptr", out_next_ptr, exp_t ? tp : cp + 32'd1);
    chk("R9 out_valid", {31'b0, out_valid}, 32'd1);
  endtask

  initial begin
    logic        h_t, h_b;
    logic [31:0] h_p;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 valid", {31'b0, out_valid}, 32'd0);
    chk("R1 taken", {31'b0, out_taken}, 32'd0);
    chk("R1 bad", {31'b0, out_bad_cond}, 32'd0);
    chk("R1 next", out_next_ptr, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    for (int c = 0; c < 16; c++) begin
      for (int i = 0; i < 6; i++) begin
        for (int j = 0; j < 6; j++) begin
          apply(4'(c), 1'b0, pick(i), pick(j), 16'h1234,
                32'h100 + 32'(i * 6 + j), 32'hA000 + 32'(c));
          // register operand chosen to disagree with the immediate
          apply(4'(c), 1'b1, pick(i), ~{{16{pick_imm(j)[15]}}, pick_imm(j)},
                pick_imm(j), 32'h200 + 32'(i * 6 + j), 32'hB000 + 32'(c));
        end
      end
    end

    // R8: sequential pointer wraps
    apply(4'h2, 1'b0, 32'd1, 32'd2, 16'h0, 32'hFFFF_FFFF, 32'h1234);
    chk("R8 wrap", out_next_ptr, 32'h0);

    // R9: idle cycles with changed inputs hold results
    h_t = out_taken; h_b = out_bad_cond; h_p = out_next_ptr;
    @(negedge clk);
    in_valid = 1'b0; cond_code = 4'h0; cur_ptr = 32'h55; target_ptr = 32'h99;
    repeat (2) @(posedge clk);
    #1;
    chk("R9 idle valid", {31'b0, out_valid}, 32'd0);
    chk("R9 idle taken", {31'b0, out_taken}, {31'b0, h_t});
    chk("R9 idle bad", {31'b0, out_bad_cond}, {31'b0, h_b});
    chk("R9 idle next", out_next_ptr, h_p);

    // R1: reset after activity
    apply(4'h0, 1'b0, 32'd0, 32'd0, 16'h0, 32'h10, 32'h77);
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(posedge clk);
    #1;
    chk("R1 re-reset taken", {31'b0, out_taken}, 32'd0);
    chk("R1 re-reset next", out_next_ptr, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule